// File: doc/BRIEF.md
# Atomic Memory Unit with Linked Reservations

This block is a small word-addressed shared memory that several requesters use to build locks, counters and lock-free updates. Each requester port issues one operation at a time: a plain load or store, a load-linked, a store-conditional, an atomic exchange, a test-and-set or a fetch-and-increment. Every operation reads and, where needed, writes its word in a single indivisible step. No other operation can slip in between the read and the write.

A fixed-priority arbiter accepts one operation per cycle, and the lowest-numbered requesting port wins. A port that is not granted keeps its request asserted until it is granted. Every port has its own reservation, made of a valid flag and an address. A load-linked sets the reservation. A successful write of any kind to that address, from any port, clears it. A store-conditional writes only while its reservation is intact, and it reports 1 on success and 0 on failure. The result of an accepted operation is returned on the issuing port one cycle after acceptance.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset the memory holds zero in every word, no reservation is valid, `rsp_valid` is all zero, and `req_ready` is zero while no request is valid.
- R2: In each cycle at most one request is accepted. `req_ready` is asserted for the lowest-indexed port whose `req_valid` is high, and for no other port. A waiting port is accepted in a later cycle once no lower port requests.
- R3: An operation accepted at a clock edge raises `rsp_valid` for that port only, for exactly the following cycle, with the result on that port's `rsp_data` slice.
- R4: The opcode field is 3 bits wide: 0 load, 1 store, 2 load-linked, 3 store-conditional, 4 exchange, 5 test-and-set, 6 fetch-and-increment. Code 7 behaves as a load. A load returns the word. A store writes the write data and returns 0.
- R5: A load-linked returns the word and records a reservation for that address on the issuing port. This replaces any earlier reservation held by that port.
- R6: A store-conditional whose port holds a valid reservation for the same address writes the write data and returns 1.
- R7: A store-conditional fails, returns 0 and leaves memory unchanged in each of these cases: its port holds no reservation, its port's reservation is for another address, or a write to that address by any port, including its own, came after its load-linked.
- R8: Every store-conditional clears the issuing port's reservation, so a second store-conditional without a new load-linked fails.
- R9: An exchange writes the write data and returns the old word. With a 1 written, a returned 0 means a lock at 0 (free) was acquired, and a returned 1 means it was already held.
- R10: A test-and-set returns the old word and writes 1 only when the old word is 0. When the old word is nonzero it writes nothing and leaves reservations intact.
- R11: A fetch-and-increment returns the old word and stores the old word plus one, wrapping modulo 2^DATA_W.
- R12: Any write that takes effect (store, successful store-conditional, exchange, successful test-and-set, increment) clears every port's reservation on that address. Reservations on other addresses are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request valid, one bit per port |
| req_ready | output | NUM_PORTS | Grant; the request is accepted at the edge where valid and ready are both high |
| req_op | input | NUM_PORTS*3 | Opcode per port, port p in bits [3p+2:3p] |
| req_addr | input | NUM_PORTS*ADDR_W | Word address per port |
| req_wdata | input | NUM_PORTS*DATA_W | Write data per port |
| rsp_valid | output | NUM_PORTS | Result valid, one bit per port |
| rsp_data | output | NUM_PORTS*DATA_W | Result per port |

## Verification
The hardest case to reach from the ports is a reservation broken by a write that lands between a port's load-linked and its store-conditional, in particular a write issued by the same port, or a test-and-set that fails and therefore must not break anything. The stimulus builds each of these as an explicit three-step sequence: link, then an intervening write or failed test, then the store-conditional. It confirms the outcome with a later load of the same word. Arbitration is reached by raising three ports in the same cycle, all incrementing one counter, so the order of the returned values shows the grant order.

// File: rtl/atom_pkg.sv
package atom_pkg;
   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_LINK  = 3'd2,
      OP_COND  = 3'd3,
      OP_SWAP  = 3'd4,
      OP_TSET  = 3'd5,
      OP_INCR  = 3'd6,
      OP_RSVD  = 3'd7
   } atom_op_e;

   localparam int unsigned OP_W = 3;
endpackage

// File: rtl/atom_arbiter.sv
module atom_arbiter #(
   parameter int unsigned NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req,
   output logic [NUM_PORTS-1:0] grant
);
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("atom_arbiter: NUM_PORTS must be at least 1");
   end

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_grant
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_lower
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end

      // a refused requester must keep asking until served
      AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (req[i] && !grant[i]) |=> req[i]); // R2
   end
endmodule

// File: rtl/atom_resv.sv
module atom_resv
   import atom_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned ADDR_W    = 6,
   localparam int unsigned SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [SEL_W-1:0]  sel,
   input  atom_op_e          op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   output logic              hit
);
   logic [NUM_PORTS-1:0] link_vld;
   logic [ADDR_W-1:0]    link_adr [NUM_PORTS];

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slot
      logic mine;
      assign mine = fire && (sel == SEL_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            link_vld[i] <= 1'b0;
            link_adr[i] <= '0;
         end else begin
            if (wr_en && link_adr[i] == addr) link_vld[i] <= 1'b0;
            if (mine && op == OP_LINK) begin
               link_vld[i] <= 1'b1;
               link_adr[i] <= addr;
            end else if (mine && op == OP_COND) begin
               link_vld[i] <= 1'b0;
            end
         end
      end

      AST_COND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (mine && op == OP_COND) |=> !link_vld[i]); // R8
      AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && link_vld[i] && link_adr[i] == addr) |=> !link_vld[i]); // R12
   end

   assign hit = link_vld[sel] && (link_adr[sel] == addr);
endmodule

// File: rtl/atom_alu.sv
module atom_alu
   import atom_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  atom_op_e          op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] wdata,
   input  logic              link_ok,
   output logic              wr_en,
   output logic [DATA_W-1:0] new_val,
   output logic [DATA_W-1:0] result
);
   always_comb begin
      wr_en   = 1'b0;
      new_val = wdata;
      result  = old_val;
      unique case (op)
         OP_STORE: begin
            wr_en  = 1'b1;
            result = '0;
         end
         OP_COND: begin
            wr_en  = link_ok;
            result = DATA_W'(link_ok);
         end
         OP_SWAP: wr_en = 1'b1;
         OP_TSET: begin
            wr_en   = (old_val == '0);
            new_val = DATA_W'(1);
         end
         OP_INCR: begin
            wr_en   = 1'b1;
            new_val = old_val + DATA_W'(1);
         end
         default: ; // load, link and the spare code only read
      endcase
   end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
   import atom_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          req_valid,
   output logic [NUM_PORTS-1:0]          req_ready,
   input  logic [NUM_PORTS*OP_W-1:0]     req_op,
   input  logic [NUM_PORTS*ADDR_W-1:0]   req_addr,
   input  logic [NUM_PORTS*DATA_W-1:0]   req_wdata,
   output logic [NUM_PORTS-1:0]          rsp_valid,
   output logic [NUM_PORTS*DATA_W-1:0]   rsp_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("atomic_mem_unit: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("atomic_mem_unit: DATA_W must be at least 2");
   end

   logic [OP_W-1:0]   op_a   [NUM_PORTS];
   logic [ADDR_W-1:0] addr_a [NUM_PORTS];
   logic [DATA_W-1:0] wd_a   [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
      assign op_a[p]   = req_op[p*OP_W +: OP_W];
      assign addr_a[p] = req_addr[p*ADDR_W +: ADDR_W];
      assign wd_a[p]   = req_wdata[p*DATA_W +: DATA_W];
   end

   logic [NUM_PORTS-1:0] grant;
   atom_arbiter #(.NUM_PORTS(NUM_PORTS)) i_arb (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .grant(grant));
   assign req_ready = grant;

   logic [SEL_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (req_valid[p]) sel = SEL_W'(p);
      end
   end

   logic              fire;
   atom_op_e          cur_op;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] old_val, new_val, result;
   logic              link_ok, wr_en, mem_we;

   assign fire     = |req_valid;
   assign cur_op   = atom_op_e'(op_a[sel]);
   assign cur_addr = addr_a[sel];
   assign old_val  = mem[cur_addr];
   assign mem_we   = fire && wr_en;

   atom_resv #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) i_resv (
      .clk(clk), .rst_n(rst_n), .fire(fire), .sel(sel), .op(cur_op),
      .addr(cur_addr), .wr_en(mem_we), .hit(link_ok));

   atom_alu #(.DATA_W(DATA_W)) i_alu (
      .op(cur_op), .old_val(old_val), .wdata(wd_a[sel]), .link_ok(link_ok),
      .wr_en(wr_en), .new_val(new_val), .result(result));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (mem_we) begin
         mem[cur_addr] <= new_val;
      end
   end

   logic [DATA_W-1:0] rsp_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_q     <= '0;
      end else begin
         rsp_valid <= grant;
         if (fire) rsp_q <= result;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
      assign rsp_data[p*DATA_W +: DATA_W] = rsp_q;
   end

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> $countones(rsp_valid) == 1); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> rsp_valid == '0); // R3
   AST_COND_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cur_op == OP_COND && !link_ok)
         |=> mem[$past(cur_addr)] == $past(old_val)); // R7
   AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cur_op == OP_INCR)
         |=> mem[$past(cur_addr)] == $past(old_val) + DATA_W'(1)); // R11
endmodule

// File: tb/test_atomic_mem_unit.sv
module test_atomic_mem_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int AW = 6;
   localparam int DW = 32;

   localparam logic [2:0] LD = 3'd0, ST = 3'd1, LL = 3'd2, SC = 3'd3,
                          XC = 3'd4, TS = 3'd5, FI = 3'd6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   req_valid = '0;
   logic [NP-1:0]   req_ready;
   logic [NP*3-1:0] req_op = '0;
   logic [NP*AW-1:0] req_addr = '0;
   logic [NP*DW-1:0] req_wdata = '0;
   logic [NP-1:0]   rsp_valid;
   logic [NP*DW-1:0] rsp_data;

   int checks = 0;
   int failures = 0;

   typedef struct {
      int          port;
      logic [DW-1:0] val;
      string       tag;
   } exp_t;
   exp_t sb [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   atomic_mem_unit #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) i_atomic_mem_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // driver: present request, wait for grant, push expectation
   task automatic issue(input int p, input logic [2:0] op, input int addr,
                        input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                        input string tag);
      exp_t e;
      req_valid[p] = 1'b1;
      req_op[p*3 +: 3] = op;
      req_addr[p*AW +: AW] = AW'(addr);
      req_wdata[p*DW +: DW] = wd;
      do @(posedge clk); while (!req_ready[p]);
      e.port = p; e.val = exp; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid[p] = 1'b0;
      check(rsp_valid[p] === 1'b1, "R3 response one cycle after accept",
            DW'(rsp_valid[p]), 1);
   endtask

   // monitor: compare each result against the queue head
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (rsp_valid[p]) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R3 unexpected response", DW'(p), 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(e.port == p, {e.tag, " (port)"}, DW'(p), DW'(e.port));
                  check(rsp_data[p*DW +: DW] === e.val, e.tag,
                        rsp_data[p*DW +: DW], e.val);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == '0, "R1 no response after reset", DW'(rsp_valid), 0);
      check(req_ready == '0, "R1 no grant while idle", DW'(req_ready), 0);

      issue(0, LD, 5, 0, 0, "R1 memory reads zero");
      issue(1, SC, 5, 7, 0, "R1 r7_ cond without link fails");
      issue(0, LD, 5, 0, 0, "R7 failed cond left word");
      issue(2, 3'd7, 5, 0, 0, "R4 spare code reads");

      issue(0, ST, 3, 32'h1234, 0, "R4 store returns zero");
      issue(2, LD, 3, 0, 32'h1234, "R4 load sees store");

      issue(1, LL, 3, 0, 32'h1234, "R5 link returns word");
      issue(1, SC, 3, 32'h55, 1, "R6 cond succeeds");
      issue(0, LD, 3, 0, 32'h55, "R6 cond wrote");
      issue(1, SC, 3, 32'h99, 0, "R8 second cond fails");
      issue(0, LD, 3, 0, 32'h55, "R8 second cond no write");

      issue(2, LL, 3, 0, 32'h55, "R5 link port2");
      issue(0, ST, 3, 32'h66, 0, "R12 other port store");
      issue(2, SC, 3, 32'h77, 0, "R12 broken by other port");
      issue(0, LD, 3, 0, 32'h66, "R7 broken cond no write");

      issue(3, LL, 3, 0, 32'h66, "R5 link a3");
      issue(3, LL, 4, 0, 0, "R5 link replaced by a4");
      issue(3, SC, 3, 32'h11, 0, "R7 cond on other address fails");

      issue(1, LL, 8, 0, 0, "R5 link a8");
      issue(1, ST, 8, 9, 0, "R4 own store");
      issue(1, SC, 8, 32'h22, 0, "R7 broken by own store");
      issue(0, LD, 8, 0, 9, "R7 own break keeps store");

      issue(2, LL, 10, 0, 0, "R5 link a10");
      issue(0, ST, 11, 5, 0, "R12 store elsewhere");
      issue(2, SC, 10, 32'hAB, 1, "R12 other address leaves link");

      issue(0, XC, 20, 1, 0, "R9 lock acquired");
      issue(1, XC, 20, 1, 1, "R9 lock already held");
      issue(2, LD, 20, 0, 1, "R9 word held");

      issue(0, TS, 21, 0, 0, "R10 set on zero");
      issue(1, LD, 21, 0, 1, "R10 word now one");
      issue(2, LL, 21, 0, 1, "R5 link a21");
      issue(0, TS, 21, 0, 1, "R10 set on nonzero returns old");
      issue(2, SC, 21, 0, 1, "R10 failed set keeps link");
      issue(3, LD, 21, 0, 0, "R10 cond stored zero");

      issue(0, FI, 30, 0, 0, "R11 increment from zero");
      issue(1, FI, 30, 0, 1, "R11 increment again");
      issue(2, LD, 30, 0, 2, "R11 counter value");
      issue(0, ST, 31, 32'hFFFF_FFFF, 0, "R4 store all ones");
      issue(3, FI, 31, 0, 32'hFFFF_FFFF, "R11 increment at max");
      issue(0, LD, 31, 0, 0, "R11 wrap to zero");

      // three ports contend in one cycle
      req_valid[3:1] = 3'b111;
      for (int p = 1; p < 4; p++) begin
         req_op[p*3 +: 3] = FI;
         req_addr[p*AW +: AW] = AW'(30);
      end
      #1;
      check(req_ready == 4'b0010, "R2 lowest port granted", DW'(req_ready), 32'h2);
      fork
         issue(1, FI, 30, 0, 2, "R2 port1 first");
         issue(2, FI, 30, 0, 3, "R2 port2 second");
         issue(3, FI, 30, 0, 4, "R2 port3 third");
      join
      issue(0, LD, 30, 0, 5, "R2 all three applied");

      repeat (2) @(negedge clk);
      check(sb.size() == 0, "R3 every expected result seen", DW'(sb.size()), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule